// File: doc/BRIEF.md
# Programmable Interval Timer with Reload

This block is a down-counting interval timer that sits behind a small register interface. A prescaler turns the input clock into ticks, and each tick lowers the count by one. Software programs a modulus and then sets the enable bit. When the count passes zero, the block sets a sticky flag and, if interrupts are enabled, raises an interrupt request. A single control bit chooses the mode. In periodic mode the counter reloads from the modulus. In one-shot mode it wraps to all-ones and keeps counting.

Software stops the timer before it changes the mode or the modulus. It clears the flag by writing a one to the flag bit while writing the other control bits back unchanged. An overwrite option lets a modulus write load the counter straight away, which is how the next one-shot interval is started. The register port is plain: a write strobe, an address and write data, with combinational read data. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `pit_timer`

## Requirements
- R1: After reset the control register reads 0x0000, the modulus reads 0xFFFF, the counter reads 0xFFFF and `irq` is low.
- R2: A control write that sets the run bit (bit 0) while the timer is stopped loads the counter from the modulus. After that, each tick lowers the count by one. A control write while the timer is already running does not reload the counter.
- R3: With the divide select (bit 5) clear, every clock cycle is a tick. With it set, one tick occurs every 2^PS_LOG2 cycles (64 by default), counted from the moment the counter was loaded.
- R4: With the reload bit (bit 1) set, the tick that finds the count at 0 loads the counter from the modulus and sets the flag (bit 2) on the same clock edge.
- R5: With the reload bit clear, the tick that finds the count at 0 loads the counter with 0xFFFF and sets the flag. Counting then continues.
- R6: Writing the control register with bit 2 set clears the flag. Writing it with bit 2 clear leaves the flag unchanged. If an expiry and a clear happen in the same cycle, the expiry wins.
- R7: `irq` is high exactly while the flag and the interrupt-enable bit (bit 3) are both set. It stays high until the flag is cleared.
- R8: With the overwrite bit (bit 4) set, a modulus write loads the counter with the written value at once and restarts the prescaler. With it clear, the counter is not touched, and the new modulus is first used at the next reload.
- R9: While the run bit is clear, the counter holds its value and the prescaler stays reset.
- R10: Address 0 is the control register, address 1 the modulus and address 2 the counter, which is read-only. Address 3 reads 0. Writes to addresses 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request (flag AND interrupt enable) |

## Verification
The bench goes after the edge where the count passes zero. A design that reloads one tick early or late gives the wrong count in the cycle after expiry. A design that reloads in one-shot mode shows the modulus instead of 0xFFFF.

It also checks that a modulus write with overwrite clear leaves the running count alone but is picked up at the next reload. A design that loads it at once, or never, is caught there. A design that does not restart the prescaler on an overwrite load, or on enable, decrements at the wrong cycle under divide-by-64.

Finally, a control write with bit 2 clear must leave the flag set, and a rewrite of the control register while running must not restart the count. A design that treats the flag as plain read/write, or reloads on every enable write, fails these checks.

// File: rtl/pit_pkg.sv
package pit_pkg;
  // register addresses
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_MOD  = 2'd1;
  localparam logic [1:0] A_CNT  = 2'd2;

  // control bit positions
  localparam int B_RUN  = 0;
  localparam int B_RLD  = 1;
  localparam int B_FLAG = 2;
  localparam int B_IE   = 3;
  localparam int B_OVW  = 4;
  localparam int B_DIV  = 5;
  localparam int CTRL_W = 6;

  typedef struct packed {
    logic div_sel;
    logic ovw;
    logic ie;
    logic flag;
    logic reload;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             expire,
  output ctrl_t            ctrl,
  output logic [CNT_W-1:0] modulus,
  output logic             start,
  output logic             mod_load,
  output logic             flag_clr
);
  logic ctrl_we, mod_we;

  assign ctrl_we  = we && (addr == A_CTRL);
  assign mod_we   = we && (addr == A_MOD);
  assign start    = ctrl_we && wdata[B_RUN] && !ctrl.run;
  assign mod_load = mod_we && ctrl.ovw;
  assign flag_clr = ctrl_we && wdata[B_FLAG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl.run     <= 1'b0;
      ctrl.reload  <= 1'b0;
      ctrl.ie      <= 1'b0;
      ctrl.ovw     <= 1'b0;
      ctrl.div_sel <= 1'b0;
    end else if (ctrl_we) begin
      ctrl.run     <= wdata[B_RUN];
      ctrl.reload  <= wdata[B_RLD];
      ctrl.ie      <= wdata[B_IE];
      ctrl.ovw     <= wdata[B_OVW];
      ctrl.div_sel <= wdata[B_DIV];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl.flag <= 1'b0;
    else if (expire)   ctrl.flag <= 1'b1;
    else if (flag_clr) ctrl.flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      modulus <= '1;
    else if (mod_we) modulus <= wdata;
  end

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> ctrl.flag);
  p_flag_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.flag && !flag_clr) |=> ctrl.flag);
endmodule

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int PS_LOG2 = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic div_sel,
  output logic tick
);
  localparam int PS_W = (PS_LOG2 > 0) ? PS_LOG2 : 1;

  generate
    if (PS_LOG2 > 0) begin : g_div
      localparam logic [PS_W-1:0] PS_MAX = '1;
      logic [PS_W-1:0] pcnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               pcnt <= '0;
        else if (!run || restart) pcnt <= '0;
        else                      pcnt <= pcnt + 1'b1;
      end

      assign tick = run && (!div_sel || (pcnt == PS_MAX));

      p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_sel) |=> (!tick || !div_sel));
      p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pcnt == '0));
    end else begin : g_nodiv
      assign tick = run;
    end
  endgenerate
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             reload,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] modulus,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic at_zero;

  assign at_zero = (count == '0);
  assign expire  = run && tick && !load && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= '1;
    else if (load)             count <= load_val;
    else if (run && tick) begin
      if (at_zero)             count <= reload ? modulus : '1;
      else                     count <= count - 1'b1;
    end
  end

  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !load && !at_zero) |=> (count == $past(count) - 1'b1));
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && reload) |=> (count == $past(modulus)));
  p_oneshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !reload) |=> (count == '1));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(count));
  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)));
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PS_LOG2 = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             irq
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] modulus, count, load_val;
  logic             start, mod_load, flag_clr, expire, tick, load;

  pit_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .expire(expire), .ctrl(ctrl), .modulus(modulus), .start(start),
    .mod_load(mod_load), .flag_clr(flag_clr)
  );

  assign load     = start || mod_load;
  assign load_val = mod_load ? reg_wdata : modulus;

  pit_prescaler #(.PS_LOG2(PS_LOG2)) u_ps (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .restart(load),
    .div_sel(ctrl.div_sel), .tick(tick)
  );

  pit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .tick(tick), .reload(ctrl.reload),
    .load(load), .load_val(load_val), .modulus(modulus), .count(count),
    .expire(expire)
  );

  assign irq = ctrl.flag && ctrl.ie;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL:  reg_rdata[CTRL_W-1:0] = ctrl;
      A_MOD:   reg_rdata = modulus;
      A_CNT:   reg_rdata = count;
      default: reg_rdata = '0;
    endcase
  end

  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_we && reg_addr == A_CTRL)) |=> irq);
  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(expire) || $past(reg_we && reg_addr == A_CTRL)));
endmodule

// File: tb/pit_timer_test.sv
module pit_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] RUN = 16'h01, RLD = 16'h02, FLG = 16'h04,
                          IE = 16'h08, OVW = 16'h10, DIV = 16'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pit_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(2'd0, v); chk("R1 ctrl", v, 16'h0000);
    rd(2'd1, v); chk("R1 mod", v, 16'hFFFF);
    rd(2'd2, v); chk("R1 cnt", v, 16'hFFFF);
    chk("R1 irq", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_periodic;
    logic [15:0] v;
    wr(2'd1, 16'd5);
    rd(2'd2, v); chk("R8 no load when ovw clear", v, 16'hFFFF);
    wr(2'd0, RUN | RLD | IE);
    rd(2'd2, v); chk("R2 load on enable", v, 16'd5);
    cyc(3); rd(2'd2, v); chk("R2 decrement", v, 16'd2);
    cyc(2); rd(2'd2, v); chk("R2 at zero", v, 16'd0);
    chk("R7 no irq yet", {15'd0, irq}, 16'h0);
    cyc(1); rd(2'd2, v); chk("R4 reload", v, 16'd5);
    rd(2'd0, v); chk("R4 flag set", v, RUN | RLD | IE | FLG);
    chk("R7 irq high", {15'd0, irq}, 16'h1);
    cyc(3); chk("R7 irq held", {15'd0, irq}, 16'h1);
    wr(2'd0, RUN | RLD | IE | FLG);
    rd(2'd2, v); chk("R2 no reload on rewrite", v, 16'd1);
    rd(2'd0, v); chk("R6 w1c clears", v, RUN | RLD | IE);
    chk("R7 irq low", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_late_mod;
    logic [15:0] v;
    wr(2'd1, 16'd8);
    rd(2'd2, v); chk("R8 running count kept", v, 16'd0);
    cyc(1); rd(2'd2, v); chk("R8 new modulus at reload", v, 16'd8);
    wr(2'd0, RUN | RLD | IE);
    rd(2'd0, v); chk("R6 write 0 keeps flag", v, RUN | RLD | IE | FLG);
  endtask

  task automatic t_oneshot;
    logic [15:0] v, held;
    wr(2'd0, FLG);
    rd(2'd2, held);
    cyc(4); rd(2'd2, v); chk("R9 hold when stopped", v, held);
    wr(2'd1, 16'd3);
    wr(2'd0, RUN);
    rd(2'd2, v); chk("R5 load", v, 16'd3);
    cyc(3); rd(2'd2, v); chk("R5 zero", v, 16'd0);
    cyc(1); rd(2'd2, v); chk("R5 wrap to ones", v, 16'hFFFF);
    rd(2'd0, v); chk("R5 flag", v, RUN | FLG);
    chk("R7 irq masked", {15'd0, irq}, 16'h0);
    cyc(2); rd(2'd2, v); chk("R5 keeps counting", v, 16'hFFFD);
    wr(2'd0, RUN | IE);
    chk("R7 irq on enable", {15'd0, irq}, 16'h1);
    rd(2'd2, v); chk("R2 running rewrite", v, 16'hFFFC);
  endtask

  task automatic t_overwrite;
    logic [15:0] v;
    wr(2'd0, RUN | RLD | OVW | FLG);
    wr(2'd1, 16'h0020);
    rd(2'd2, v); chk("R8 immediate load", v, 16'h0020);
    cyc(2); rd(2'd2, v); chk("R8 counts from new", v, 16'h001E);
  endtask

  task automatic t_prescale;
    logic [15:0] v;
    wr(2'd0, 16'h0);
    wr(2'd1, 16'd2);
    wr(2'd0, RUN | RLD | DIV | OVW);
    rd(2'd2, v); chk("R3 load", v, 16'd2);
    cyc(63); rd(2'd2, v); chk("R3 no tick before 64", v, 16'd2);
    cyc(1); rd(2'd2, v); chk("R3 tick at 64", v, 16'd1);
    cyc(30);
    wr(2'd1, 16'd7);
    rd(2'd2, v); chk("R8 ovw load under div", v, 16'd7);
    cyc(63); rd(2'd2, v); chk("R8 prescaler restarted", v, 16'd7);
    cyc(1); rd(2'd2, v); chk("R8 first tick after restart", v, 16'd6);
  endtask

  task automatic t_map;
    logic [15:0] v, held;
    wr(2'd0, 16'h0);
    rd(2'd2, held);
    wr(2'd2, 16'h1234);
    rd(2'd2, v); chk("R10 counter read-only", v, held);
    wr(2'd3, 16'hABCD);
    rd(2'd3, v); chk("R10 addr3 reads 0", v, 16'h0000);
    rd(2'd1, v); chk("R10 modulus readback", v, 16'd7);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_periodic;
    t_late_mod;
    t_oneshot;
    t_overwrite;
    t_prescale;
    t_map;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule